// File: doc/BRIEF.md
# Flag-Qualified ADC Sample Averager

This block averages readings from an on-chip ADC that sits behind a read-request and read-response handshake. A one-cycle `start` pulse launches a run. The block then issues read requests one at a time. Each response returns a 16-bit word. One bit in that word marks whether the conversion is complete. Only marked words count as samples, but every response counts as an attempt.

A run has two phases. The warm-up phase throws away a small number of good samples so that stale conversions are flushed. The gathering phase adds up a fixed number of good 10-bit values. The sum is then multiplied by 1000 and divided by the nominal sample count in a sequential divider. The quotient is a fixed-point mean with three decimal digits of fraction. It is registered together with a one-cycle completion pulse.

Each phase has its own budget of reads. When a phase spends its budget before it has enough good samples, the phase ends anyway and a sticky error flag is raised. In that case the mean is still taken over the nominal sample count.

Top module: `adc_avg_top`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `rd_req` and `overrun` are low and `avg_out` is zero.
- R2: A `start` pulse while idle begins a run. `rd_req` is a one-cycle pulse, and no further request is issued until `rd_ack` has answered the previous one.
- R3: In each response word, bit 10 is the conversion-valid flag and bits 9:0 are the value. Bits 15:11 have no effect on the result.
- R4: The warm-up phase ends after 2 valid responses. Their values never enter the sum.
- R5: The gathering phase adds the values of valid responses until 80 have been taken. Responses without the valid flag add nothing but still count as attempts.
- R6: Each phase performs at most 200 reads, and the attempt count restarts at the beginning of each phase. A phase that reaches 200 reads without its quota ends there and sets `overrun`. `overrun` stays set until the next run starts.
- R7: `avg_out` equals floor(S × 1000 / 80), where S is the sum gathered in the run, including a short sum after an overrun.
- R8: `done` is high for exactly one cycle, in the cycle where `avg_out` takes its new value and `busy` is already low. `avg_out` then holds until the next completion.
- R9: A `start` pulse while a run is in progress is ignored. The run continues with the same read count and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run |
| rd_req | output | 1 | One-cycle read request to the ADC register |
| rd_ack | input | 1 | Response strobe; `rd_data` is valid while high |
| rd_data | input | 16 | Response word: flag at bit 10, value in 9:0 |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a new mean is available |
| overrun | output | 1 | Sticky flag: a phase spent its read budget |
| avg_out | output | 27 | Mean scaled by 1000 |

## Verification
Faults in the valid-sample or attempt counters show up at the ports as a wrong number of `rd_req` pulses per run. They can also show up as an `overrun` flag with the wrong value. The bench counts both in every run. A slip in phase sequencing, such as warm-up samples leaking into the sum or a budget not restarted, shifts `avg_out` away from the mean the bench computes. The bench sees this at the first `done` after the fault. A fault in the divider or the scale factor corrupts every result and is caught at the same pulse. Cases at the exact budget boundary, at full-scale and zero values, and with junk in the upper bits separate off-by-one errors from correct behaviour.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SCALE
  } seq_state_e;

  typedef enum logic {
    PH_WARMUP,
    PH_GATHER
  } phase_e;
endpackage

// File: rtl/adc_avg_seq.sv
module adc_avg_seq
  import adc_avg_pkg::*;
#(
  parameter int DISCARD_N   = 2,
  parameter int ACC_N       = 80,
  parameter int ATTEMPT_MAX = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rd_ack,
  input  logic rd_flag,
  input  logic scale_done,
  output logic rd_req,
  output logic busy,
  output logic overrun,
  output logic clr_acc,
  output logic acc_en,
  output logic scale_go
);
  localparam int ATT_W = $clog2(ATTEMPT_MAX + 1);
  localparam int TGT_MAX = (DISCARD_N > ACC_N) ? DISCARD_N : ACC_N;
  localparam int CNT_W = $clog2(TGT_MAX + 1);

  seq_state_e       state;
  phase_e           phase;
  logic [ATT_W-1:0] att;
  logic [CNT_W-1:0] cnt;

  logic [ATT_W-1:0] att_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] target;
  logic             quota_met;
  logic             budget_out;

  always_comb begin
    att_nxt    = att + ATT_W'(1);
    cnt_nxt    = cnt + CNT_W'(rd_flag);
    target     = (phase == PH_WARMUP) ? CNT_W'(DISCARD_N) : CNT_W'(ACC_N);
    quota_met  = (cnt_nxt == target);
    budget_out = (att_nxt == ATT_W'(ATTEMPT_MAX));
    clr_acc    = (state == ST_IDLE) && start;
    acc_en     = (state == ST_WAIT) && rd_ack && rd_flag && (phase == PH_GATHER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_WARMUP;
      att      <= '0;
      cnt      <= '0;
      rd_req   <= 1'b0;
      busy     <= 1'b0;
      overrun  <= 1'b0;
      scale_go <= 1'b0;
    end else begin
      rd_req   <= 1'b0;
      scale_go <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ISSUE;
            phase   <= PH_WARMUP;
            att     <= '0;
            cnt     <= '0;
            overrun <= 1'b0;
            busy    <= 1'b1;
          end
        end
        ST_ISSUE: begin
          rd_req <= 1'b1;
          state  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_ack) begin
            if (quota_met || budget_out) begin
              if (!quota_met) overrun <= 1'b1;
              if (phase == PH_WARMUP) begin
                phase <= PH_GATHER;
                att   <= '0;
                cnt   <= '0;
                state <= ST_ISSUE;
              end else begin
                att      <= att_nxt;
                cnt      <= cnt_nxt;
                state    <= ST_SCALE;
                scale_go <= 1'b1;
              end
            end else begin
              att   <= att_nxt;
              cnt   <= cnt_nxt;
              state <= ST_ISSUE;
            end
          end
        end
        ST_SCALE: begin
          if (scale_done) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R2
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy); // R2
  AST_ATT_BOUND: assert property (@(posedge clk) disable iff (rst)
    att <= ATT_W'(ATTEMPT_MAX)); // R6
  AST_OVR_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> ($past(att) == ATT_W'(ATTEMPT_MAX - 1))); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && start && !rd_ack) |=> (state == ST_WAIT && phase == $past(phase))); // R9
  AST_WARMUP_NO_ADD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WARMUP) |-> !acc_en); // R4
endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum #(
  parameter int VAL_W = 10,
  parameter int SUM_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [VAL_W-1:0] add_val,
  output logic [SUM_W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (add_en) sum <= sum + SUM_W'(add_val);
  end

  AST_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (add_en && !clr) |=> (sum >= $past(sum))); // R5
endmodule

// File: rtl/adc_avg_scale.sv
module adc_avg_scale #(
  parameter int SUM_W   = 17,
  parameter int SCALE   = 1000,
  parameter int DIVISOR = 80,
  parameter int PROD_W  = 27,
  parameter int RES_MAX = 1023000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [SUM_W-1:0]  sum_in,
  output logic [PROD_W-1:0] quot,
  output logic              q_valid
);
  localparam int R_W    = $clog2(DIVISOR + 1) + 1;
  localparam int ITER_W = $clog2(PROD_W + 1);
  localparam logic [PROD_W-1:0] SCALE_C = PROD_W'(SCALE);
  localparam logic [R_W-1:0]    DIV_C   = R_W'(DIVISOR);

  logic [PROD_W-1:0] dvd;
  logic [R_W-2:0]    rem;
  logic [ITER_W-1:0] iter;
  logic              run;
  logic [R_W-1:0]    shifted;
  logic              fits;

  always_comb begin
    shifted = {rem, dvd[PROD_W-1]};
    fits    = (shifted >= DIV_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd     <= '0;
      rem     <= '0;
      iter    <= '0;
      run     <= 1'b0;
      quot    <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= 1'b0;
      if (go) begin
        dvd  <= PROD_W'(sum_in) * SCALE_C;
        rem  <= '0;
        quot <= '0;
        iter <= ITER_W'(PROD_W);
        run  <= 1'b1;
      end else if (run) begin
        dvd  <= {dvd[PROD_W-2:0], 1'b0};
        quot <= {quot[PROD_W-2:0], fits};
        rem  <= fits ? (R_W-1)'(shifted - DIV_C) : shifted[R_W-2:0];
        iter <= iter - ITER_W'(1);
        if (iter == ITER_W'(1)) begin
          run     <= 1'b0;
          q_valid <= 1'b1;
        end
      end
    end
  end

  AST_QV_PULSE: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> !q_valid); // R8
  AST_QUOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> (quot <= PROD_W'(RES_MAX))); // R7
endmodule

// File: rtl/adc_avg_top.sv
module adc_avg_top #(
  parameter int DATA_W      = 16,
  parameter int VAL_W       = 10,
  parameter int DISCARD_N   = 2,
  parameter int ACC_N       = 80,
  parameter int ATTEMPT_MAX = 200,
  parameter int SCALE       = 1000,
  localparam int VMAX       = (1 << VAL_W) - 1,
  localparam int SUM_W      = $clog2(ACC_N * VMAX + 1),
  localparam int PROD_W     = SUM_W + $clog2(SCALE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              overrun,
  output logic [PROD_W-1:0] avg_out
);
  localparam int FLAG_BIT = VAL_W;
  localparam int RES_MAX  = VMAX * SCALE;

  logic              clr_acc;
  logic              acc_en;
  logic              scale_go;
  logic              q_valid;
  logic [SUM_W-1:0]  sum;
  logic [PROD_W-1:0] quot;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^rd_data[DATA_W-1:FLAG_BIT+1];

  adc_avg_seq #(
    .DISCARD_N  (DISCARD_N),
    .ACC_N      (ACC_N),
    .ATTEMPT_MAX(ATTEMPT_MAX)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_ack    (rd_ack),
    .rd_flag   (rd_data[FLAG_BIT]),
    .scale_done(q_valid),
    .rd_req    (rd_req),
    .busy      (busy),
    .overrun   (overrun),
    .clr_acc   (clr_acc),
    .acc_en    (acc_en),
    .scale_go  (scale_go)
  );

  adc_avg_accum #(
    .VAL_W(VAL_W),
    .SUM_W(SUM_W)
  ) u_accum (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_acc),
    .add_en (acc_en),
    .add_val(rd_data[VAL_W-1:0]),
    .sum    (sum)
  );

  adc_avg_scale #(
    .SUM_W  (SUM_W),
    .SCALE  (SCALE),
    .DIVISOR(ACC_N),
    .PROD_W (PROD_W),
    .RES_MAX(RES_MAX)
  ) u_scale (
    .clk    (clk),
    .rst    (rst),
    .go     (scale_go),
    .sum_in (sum),
    .quot   (quot),
    .q_valid(q_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      avg_out <= '0;
    end else begin
      done <= q_valid;
      if (q_valid) avg_out <= quot;
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(avg_out)); // R8
endmodule

// File: tb/test_adc_avg_top.sv
module test_adc_avg_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        rd_req;
  logic        rd_ack;
  logic [15:0] rd_data;
  logic        busy;
  logic        done;
  logic        overrun;
  logic [26:0] avg_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] stim [0:511];
  int ridx = 0;
  int reads_seen = 0;
  int lat_max = 0;

  always #5 clk = ~clk;

  adc_avg_top i_adc_avg_top (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .busy(busy), .done(done), .overrun(overrun), .avg_out(avg_out)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // responder: one answer per request after a random delay
  initial begin
    rd_ack  = 1'b0;
    rd_data = 16'h0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        reads_seen++;
        repeat ($urandom_range(lat_max, 0)) begin
          @(negedge clk);
          if (rd_req) check("R2 request while outstanding", 1, 0);
        end
        rd_data = stim[ridx];
        ridx++;
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack  = 1'b0;
        rd_data = 16'($urandom);
      end
    end
  end

  function automatic logic [15:0] word(bit v, int val, bit junk);
    logic [4:0] hi;
    hi = junk ? 5'($urandom) : 5'd0;
    return {hi, v, 10'(val)};
  endfunction

  task automatic fill_rand(int pct, bit junk);
    for (int i = 0; i < 512; i++)
      stim[i] = word($urandom_range(99, 0) < pct, $urandom_range(1023, 0), junk);
  endtask

  // independent model of the two phases
  task automatic model(output int n, output longint s, output bit o);
    int idx, att, v;
    idx = 0; s = 0; o = 0;
    att = 0; v = 0;
    while (v < 2 && att < 200) begin
      if (stim[idx][10]) v++;
      idx++; att++;
    end
    if (v < 2) o = 1;
    att = 0; v = 0;
    while (v < 80 && att < 200) begin
      if (stim[idx][10]) begin v++; s += stim[idx][9:0]; end
      idx++; att++;
    end
    if (v < 80) o = 1;
    n = idx;
  endtask

  task automatic run_case(string tag, bit mid_start);
    int n; longint s; bit o;
    model(n, s, o);
    ridx = 0; reads_seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R2 busy after start"}, busy, 1);
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    check({tag, " R7 mean"}, avg_out, (s * 1000) / 80);
    check({tag, " R6 overrun"}, overrun, o);
    check({tag, " R4 R5 read count"}, reads_seen, n);
    if (mid_start) check({tag, " R9 restart ignored"}, reads_seen, n);
    check({tag, " R8 busy low at done"}, busy, 0);
    @(negedge clk);
    check({tag, " R8 done single cycle"}, done, 0);
    check({tag, " R8 mean held"}, avg_out, (s * 1000) / 80);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rd_req", rd_req, 0);
    check("R1 overrun", overrun, 0);
    check("R1 avg_out", avg_out, 0);

    // R3: all valid, junk in upper bits
    lat_max = 0; fill_rand(100, 1); run_case("allvalid_junk", 0);
    // R7: full scale values
    for (int i = 0; i < 512; i++) stim[i] = word(1, 1023, 0);
    run_case("fullscale", 0);
    for (int i = 0; i < 512; i++) stim[i] = word(1, 0, 1);
    run_case("zeros", 0);
    // R4: warm-up samples at maximum, gathered at small values
    for (int i = 0; i < 512; i++) stim[i] = word(1, (i < 2) ? 1023 : 5, 0);
    run_case("warmup_excluded", 0);
    // R5: half invalid with random latency
    lat_max = 3; fill_rand(50, 1); run_case("mixed50", 0);
    // R6: warm-up spends its budget
    for (int i = 0; i < 512; i++) stim[i] = word(i >= 200, 700, 0);
    run_case("warmup_overrun", 0);
    // R6: gather phase spends its budget
    for (int i = 0; i < 512; i++) stim[i] = word((i < 2) || (i % 10 == 0), 300 + i, 0);
    run_case("gather_overrun", 0);
    // R6: quota met on the last allowed read, no overrun
    for (int i = 0; i < 512; i++) stim[i] = word((i == 198) || (i == 199) || (i >= 200), 17, 0);
    run_case("budget_edge", 0);
    // R9: start while busy
    lat_max = 2; fill_rand(70, 1); run_case("restart_ignored", 1);
    for (int k = 0; k < 4; k++) begin
      lat_max = k; fill_rand(30 + 20 * k, 1); run_case("random", 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule